// File: doc/BRIEF.md
# Block Memory Transfer Engine

The engine moves a run of bytes from one 16-bit address range to another through a single synchronous memory port. A one-cycle `start` latches a mode code, a source address, a destination address and a 16-bit length. The engine then handles each byte as a read cycle followed by a write cycle. Read data returns on the cycle after the read strobe, and the engine forwards it unchanged to the write. Each pointer moves according to its own step, and the mode code sets the starting step of both pointers.

Five patterns are available: both pointers count up; both count down; the source counts up while the destination stays put; the source alternates while the destination counts up; and the source counts up while the destination alternates. An alternating pointer flips the sign of its step after every byte. Its starting step decides what that produces: a starting step of zero never moves, so the pointer stays fixed, and a starting step of +1 swings between two neighbouring addresses.

A length of zero stands for the full 65536-byte space. A running cycle cost, charged at a fixed rate per byte, is kept for the transfer in progress. `busy` marks the active transfer and `done` marks its end.

Top module: `blkxfer_engine`

## Requirements
- R1: After reset `busy`, `done`, `mem_rd` and `mem_wr` are 0 and `cost_cycles` is 0, and they stay so until a start arrives.
- R2: Each byte occupies one cycle with `mem_rd`=1 and `mem_addr` equal to the source pointer, then the next cycle with `mem_wr`=1, `mem_addr` equal to the destination pointer, and `mem_wdata` equal to the `mem_rdata` returned for that read. The memory returns `mem_rdata` on the cycle after `mem_rd`. `mem_rd` and `mem_wr` are never high together.
- R3: Mode code 0: for byte i, the source address is src+i and the destination address is dst+i.
- R4: Mode code 1: for byte i, the source address is src-i and the destination address is dst-i.
- R5: Mode code 2: for byte i, the source address is src+i and the destination address is always dst.
- R6: Mode code 3 (source alternating, starting step 0): the source address stays src for every byte and the destination address is dst+i.
- R7: Mode code 4 (destination alternating, starting step +1): the source address is src+i and the destination address is dst for even i and dst+1 for odd i.
- R8: Mode codes 5, 6 and 7 behave exactly like code 0.
- R9: Both pointers wrap modulo 65536, so 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R10: A length of 0 transfers 65536 bytes.
- R11: `cost_cycles` clears when a start is accepted and grows by 6 on each byte written, so it ends at 6 times the byte count.
- R12: `busy` is high from the cycle after an accepted start through the final write cycle, which is 2 cycles per byte. `done` is high for exactly one cycle, the cycle after the final write, with `busy` low.
- R13: A start while `busy` is high is ignored: the running transfer keeps its addresses, length and cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| mode | input | 3 | Addressing pattern code |
| src_addr | input | 16 | First source address |
| dst_addr | input | 16 | First destination address |
| length | input | 16 | Byte count, 0 meaning 65536 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| cost_cycles | output | 20 | Accumulated cycle cost of the current transfer |

## Verification
The hardest case to reach is the length-zero transfer. It must run the full 65536 bytes, and its source pointer must end at 0xFFFF. A monitor counts every strobe and tracks the last source address and any stray destination address, so the whole run is checked without storing it. A second hard case is a start that lands in the middle of a transfer. The bench raises it during a read phase with a different mode, address and length, and then confirms that the addresses, duration and cost of the original transfer are unchanged. The memory model returns a byte computed from the address, so every forwarded byte can be checked.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  localparam int ADDR_W = 16;

  // Signed two-bit step: 00 = hold, 01 = +1, 11 = -1
  typedef logic [1:0] step_t;
  localparam step_t STEP_HOLD = 2'b00;
  localparam step_t STEP_UP   = 2'b01;
  localparam step_t STEP_DOWN = 2'b11;

  typedef enum logic [2:0] {
    MODE_UP_UP    = 3'd0,
    MODE_DN_DN    = 3'd1,
    MODE_UP_HOLD  = 3'd2,
    MODE_SWING_UP = 3'd3,
    MODE_UP_SWING = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } state_e;

  typedef struct packed {
    step_t src_step;
    logic  src_swing;
    step_t dst_step;
    logic  dst_swing;
  } plan_t;

  // Starting steps and swing flags for each mode code
  function automatic plan_t decode_mode(input logic [2:0] code);
    plan_t p;
    p = '{src_step: STEP_UP, src_swing: 1'b0, dst_step: STEP_UP, dst_swing: 1'b0};
    case (mode_e'(code))
      MODE_DN_DN: begin
        p.src_step = STEP_DOWN;
        p.dst_step = STEP_DOWN;
      end
      MODE_UP_HOLD: p.dst_step = STEP_HOLD;
      MODE_SWING_UP: begin
        p.src_step  = STEP_HOLD;
        p.src_swing = 1'b1;
      end
      MODE_UP_SWING: p.dst_swing = 1'b1;
      default: ;
    endcase
    return p;
  endfunction

  // Address plus sign-extended step, wrapping at the address width
  function automatic logic [ADDR_W-1:0] apply_step(input logic [ADDR_W-1:0] a,
                                                   input step_t s);
    return a + {{(ADDR_W-2){s[1]}}, s};
  endfunction

  // Negate a step: +1 <-> -1, hold stays hold
  function automatic step_t flip_step(input step_t s);
    return step_t'(2'b00 - s);
  endfunction

endpackage

// File: rtl/blkxfer_ptr.sv
module blkxfer_ptr
  import blkxfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  step_t             load_step,
  input  logic              load_swing,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);

  step_t step_q;
  logic  swing_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      step_q  <= STEP_HOLD;
      swing_q <= 1'b0;
    end else if (load) begin
      addr    <= load_addr;
      step_q  <= load_step;
      swing_q <= load_swing;
    end else if (advance) begin
      addr <= apply_step(addr, step_q);
      if (swing_q) step_q <= flip_step(step_q);
    end
  end

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] length,
  output logic             accept,
  output logic             phase_rd,
  output logic             phase_wr,
  output logic             last_byte,
  output logic             busy,
  output logic             done
);

  localparam int CNT_W = LEN_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << LEN_W;
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  state_e           state;
  logic [CNT_W-1:0] remain;

  assign accept    = start && (state == ST_IDLE);
  assign phase_rd  = (state == ST_RD);
  assign phase_wr  = (state == ST_WR);
  assign last_byte = phase_wr && (remain == ONE_CNT);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      remain <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_byte;
      case (state)
        ST_IDLE: if (accept) begin
          remain <= (length == '0) ? FULL_CNT : {1'b0, length};
          state  <= ST_RD;
        end
        ST_RD: state <= ST_WR;
        ST_WR: begin
          remain <= remain - ONE_CNT;
          state  <= last_byte ? ST_IDLE : ST_RD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blkxfer_cost.sv
module blkxfer_cost #(
  parameter int COST_W    = 20,
  parameter int BYTE_COST = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              charge,
  output logic [COST_W-1:0] total
);

  localparam logic [COST_W-1:0] UNIT = COST_W'(BYTE_COST);

  always_ff @(posedge clk) begin
    if (!rst_n)      total <= '0;
    else if (clear)  total <= '0;
    else if (charge) total <= total + UNIT;
  end

endmodule

// File: rtl/blkxfer_engine.sv
module blkxfer_engine
  import blkxfer_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 8,
  parameter int COST_W    = 20,
  parameter int BYTE_COST = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [LEN_W-1:0]  length,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [COST_W-1:0] cost_cycles
);

  localparam int NPTR = 2;  // index 0 = source, 1 = destination

  plan_t plan;
  logic  accept;
  logic  phase_rd;
  logic  phase_wr;
  logic  xfer_last;

  logic [ADDR_W-1:0] ld_addr  [NPTR];
  step_t             ld_step  [NPTR];
  logic              ld_swing [NPTR];
  logic              adv      [NPTR];
  logic [ADDR_W-1:0] ptr_addr [NPTR];

  assign plan = decode_mode(mode);

  assign ld_addr[0]  = src_addr;
  assign ld_addr[1]  = dst_addr;
  assign ld_step[0]  = plan.src_step;
  assign ld_step[1]  = plan.dst_step;
  assign ld_swing[0] = plan.src_swing;
  assign ld_swing[1] = plan.dst_swing;
  assign adv[0]      = phase_rd;
  assign adv[1]      = phase_wr;

  blkxfer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .length    (length),
    .accept    (accept),
    .phase_rd  (phase_rd),
    .phase_wr  (phase_wr),
    .last_byte (xfer_last),
    .busy      (busy),
    .done      (done)
  );

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    blkxfer_ptr u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_addr  (ld_addr[g]),
      .load_step  (ld_step[g]),
      .load_swing (ld_swing[g]),
      .advance    (adv[g]),
      .addr       (ptr_addr[g])
    );
  end

  blkxfer_cost #(.COST_W(COST_W), .BYTE_COST(BYTE_COST)) u_cost (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .charge (phase_wr),
    .total  (cost_cycles)
  );

  assign mem_rd    = phase_rd;
  assign mem_wr    = phase_wr;
  assign mem_addr  = phase_wr ? ptr_addr[1] : ptr_addr[0];
  assign mem_wdata = mem_rdata;

endmodule

// File: rtl/blkxfer_engine_chk.sv
module blkxfer_engine_chk #(
  parameter int COST_W    = 20,
  parameter int BYTE_COST = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              xfer_last,
  input logic [COST_W-1:0] cost_cycles
);

  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R2

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd)); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> (done && !busy)); // R12

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R12

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr)); // R1

  AST_COST_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (cost_cycles == $past(cost_cycles) + COST_W'(BYTE_COST))); // R11

  AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_wr) |=> $stable(cost_cycles)); // R13

endmodule

bind blkxfer_engine blkxfer_engine_chk #(.COST_W(COST_W), .BYTE_COST(BYTE_COST)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .xfer_last   (xfer_last),
  .cost_cycles (cost_cycles)
);

// File: tb/blkxfer_engine_tb.sv
module blkxfer_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [15:0] src_addr = 16'h0;
  logic [15:0] dst_addr = 16'h0;
  logic [15:0] length = 16'h0;
  logic        busy, done, mem_rd, mem_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h0;
  logic [19:0] cost_cycles;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  blkxfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .src_addr(src_addr), .dst_addr(dst_addr), .length(length),
    .busy(busy), .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cost_cycles(cost_cycles)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // Registered-read memory model
  always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

  // Monitor
  logic [15:0] rd_log [16];
  logic [15:0] wr_log [16];
  int          rd_n = 0, wr_n = 0, data_bad = 0, overlap = 0, dst_off = 0;
  logic [15:0] last_rd = 16'h0;
  logic [15:0] fixed_dst = 16'h0;

  always @(negedge clk) begin
    if (mem_rd && mem_wr) overlap++;
    if (mem_rd) begin
      if (rd_n < 16) rd_log[rd_n] = mem_addr;
      rd_n++;
      last_rd = mem_addr;
    end
    if (mem_wr) begin
      if (wr_n < 16) wr_log[wr_n] = mem_addr;
      wr_n++;
      if (mem_wdata !== pat(last_rd)) data_bad++;
      if (mem_addr !== fixed_dst) dst_off++;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_src(input logic [2:0] m, input logic [15:0] s, input int i);
    case (m)
      3'd1:    return s - 16'(i);
      3'd3:    return s;
      default: return s + 16'(i);
    endcase
  endfunction

  function automatic logic [15:0] exp_dst(input logic [2:0] m, input logic [15:0] d, input int i);
    case (m)
      3'd1:    return d - 16'(i);
      3'd2:    return d;
      3'd4:    return d + 16'(i & 1);
      default: return d + 16'(i);
    endcase
  endfunction

  int busy_cnt, done_cnt;

  // Runs one transfer; poke_at > 0 raises an extra start on that busy cycle
  task automatic run_xfer(input logic [2:0] m, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] l, input int poke_at);
    int guard;
    @(negedge clk);
    rd_n = 0; wr_n = 0; data_bad = 0; overlap = 0; dst_off = 0; fixed_dst = d;
    busy_cnt = 0; done_cnt = 0; guard = 0;
    mode = m; src_addr = s; dst_addr = d; length = l; start = 1'b1;
    forever begin
      @(negedge clk);
      start = 1'b0;
      guard++;
      if (busy) busy_cnt++;
      if (poke_at > 0 && busy_cnt == poke_at) begin
        mode = 3'd1; src_addr = 16'h7777; dst_addr = 16'h6666; length = 16'd9; start = 1'b1;
      end
      if (done) begin done_cnt++; break; end
      if (guard > 140000) break;
    end
    @(negedge clk);
    start = 1'b0;
    if (done) done_cnt++;
  endtask

  task automatic check_xfer(input string req, input logic [2:0] m, input logic [15:0] s,
                            input logic [15:0] d, input logic [15:0] l);
    int n, mis;
    n = (l == 16'd0) ? 65536 : int'(l);
    mis = 0;
    for (int i = 0; i < 16 && i < n; i++) begin
      if (rd_log[i] !== exp_src(m, s, i)) mis++;
      if (wr_log[i] !== exp_dst(m, d, i)) mis++;
    end
    chk(req, "address mismatches", mis, 0);
    chk(req, "bytes read", rd_n, n);
    chk("R2", "forwarded data mismatches", data_bad, 0);
    chk("R2", "read/write overlap", overlap, 0);
    chk("R11", "final cost", cost_cycles, 6 * n);
    chk("R12", "busy cycles", busy_cnt, 2 * n);
    chk("R12", "done pulse cycles", done_cnt, 1);
    chk("R12", "busy after done", busy, 0);
  endtask

  function automatic string tag_of(input int idx);
    case (idx)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // {mode, src, dst, length}
  localparam logic [50:0] VEC [8] = '{
    {3'd0, 16'h1000, 16'h2000, 16'd5},
    {3'd1, 16'h1010, 16'h2010, 16'd4},
    {3'd2, 16'h0300, 16'h0400, 16'd3},
    {3'd3, 16'h0500, 16'h0600, 16'd4},
    {3'd4, 16'h0700, 16'h0800, 16'd5},
    {3'd6, 16'h0900, 16'h0A00, 16'd3},
    {3'd0, 16'hFFFE, 16'hFFFD, 16'd4},
    {3'd1, 16'h0001, 16'h0000, 16'd3}
  };

  initial begin
    repeat (199000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "done in reset", done, 0);
    chk("R1", "cost in reset", cost_cycles, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "strobes idle after reset", {mem_rd, mem_wr, busy, done}, 0);
    chk("R1", "cost idle after reset", cost_cycles, 0);

    for (int k = 0; k < 8; k++) begin
      run_xfer(VEC[k][50:48], VEC[k][47:32], VEC[k][31:16], VEC[k][15:0], 0);
      check_xfer(tag_of(k), VEC[k][50:48], VEC[k][47:32], VEC[k][31:16], VEC[k][15:0]);
    end

    // R13: start during busy (read phase) is ignored
    run_xfer(3'd0, 16'h2100, 16'h2200, 16'd4, 3);
    check_xfer("R13", 3'd0, 16'h2100, 16'h2200, 16'd4);

    // R10: length zero moves 65536 bytes
    run_xfer(3'd2, 16'h0000, 16'h1234, 16'd0, 0);
    check_xfer("R10", 3'd2, 16'h0000, 16'h1234, 16'd0);
    chk("R10", "bytes written", wr_n, 65536);
    chk("R10", "last source address", last_rd, 16'hFFFF);
    chk("R5", "destination moved", dst_off, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule